// File: doc/BRIEF.md
# 7:1 Serial-Link Receive Gearbox

This block sits behind the double-data-rate input cells of a source-synchronous 7:1 differential video link. It runs on the fast capture clock, which is 3.5 times the pixel rate, and takes two bits per cycle from each of four data lanes and from the forwarded clock lane. It packs each lane's serial stream into 7-bit symbols and emits one 28-bit pixel word with a one-cycle valid strobe. Because 7 bits arrive over 3.5 cycles, words are produced at alternating 4- and 3-cycle spacing.

The symbol boundary is not known when the link comes up. The block finds it alone. It compares each 7-bit symbol from the forwarded clock lane against the 1100011 pattern that marks a correctly framed pixel period. On a mismatch it moves its extraction window by one bit and lets a few symbols pass before it looks again. A lock flag reports a stable boundary, and pixel words are only presented while that flag is high.

Top module: `lvds71_rx_gearbox`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after its release, `locked_o`, `word_vld_o` and `word_o` are all zero. Reset acts asynchronously, and it clears the bit accumulator, the boundary offset and the lock state.
- R2: For lane k, bit `data_pair_i[2k+1]` is the earlier bit in time and `data_pair_i[2k]` the later one. The same order holds for `fwd_clk_pair_i[1]` and `fwd_clk_pair_i[0]`. The earliest bit of a symbol lands in its bit 6, and lane k fills `word_o[7k+6:7k]`.
- R3: A symbol completes whenever 7 or more unread bits are buffered. While `locked_o` stays high, consecutive `word_vld_o` pulses are 3 or 4 cycles apart, and successive gaps alternate.
- R4: While unlocked, a clock-lane symbol other than 1100011 moves the boundary by one bit, cyclically over the 7 positions. The next SETTLE_SYMS symbols (2 by default) are then ignored.
- R5: `locked_o` rises on the symbol that completes LOCK_MATCHES consecutive matches (4 by default), and that symbol's word is valid. Before that point the flag stays low.
- R6: While locked, a single mismatching clock symbol leaves `locked_o` high. LOSS_MISSES consecutive mismatches (2 by default) drop it, with no valid on that symbol, and start a new search.
- R7: `word_vld_o` is never high while `locked_o` is low, and `word_o` changes only together with a valid pulse.
- R8: From any of the 7 bit offsets of the incoming stream, lock is reached within 150 cycles of reset release. After a loss of lock it is regained within 200 cycles.
- R9: Once locked, the valid words reproduce the transmitted pixel sequence in order, with none skipped or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast capture clock (3.5 × pixel rate) |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| data_pair_i | input | 8 | Two captured bits per data lane, lane k at [2k+1:2k], [2k+1] earlier |
| fwd_clk_pair_i | input | 2 | Two captured bits of the forwarded clock lane, [1] earlier |
| word_o | output | 28 | Aligned pixel word, lane k at [7k+6:7k] |
| word_vld_o | output | 1 | One-cycle strobe for a new word |
| locked_o | output | 1 | Symbol boundary found and stable |

## Verification
The bench builds the block with its default parameters: four lanes, 7-bit symbols, lock after 4 matches, loss after 2 misses and a settle count of 2. With a settle count this short, a full search over all 7 boundary positions finishes in under a hundred cycles. Every stream offset can therefore be started from reset and followed by a data run. The loss threshold of 2 is reached by corrupting two clock-lane symbols in a row, and one corrupted symbol stays below it. An offset jump in mid-stream drives the block through loss and reacquisition.

// File: rtl/lvds_gear_pkg.sv
package lvds_gear_pkg;
  typedef enum logic { ST_HUNT = 1'b0, ST_LOCK = 1'b1 } align_st_e;
endpackage

// File: rtl/gb_bit_accum.sv
module gb_bit_accum #(
  parameter int unsigned SYM_W  = 7,
  parameter int unsigned FILL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              stb_o,
  output logic [FILL_W-1:0] base_o
);
  logic [FILL_W-1:0] fill_q, fill_d, sum;

  always_comb begin
    sum    = fill_q + FILL_W'(2);
    stb_o  = (sum >= FILL_W'(SYM_W));
    base_o = sum - FILL_W'(SYM_W);
    fill_d = stb_o ? base_o : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_d;
  end
endmodule

// File: rtl/gb_lane_window.sv
module gb_lane_window #(
  parameter int unsigned SYM_W   = 7,
  parameter int unsigned HIST_W  = 14,
  parameter int unsigned FILL_W  = 4,
  parameter int unsigned SLIP_W  = 3,
  parameter int unsigned SHIFT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pair_i,
  input  logic [FILL_W-1:0] base_i,
  input  logic [SLIP_W-1:0] slip_i,
  output logic [SYM_W-1:0]  sym_o
);
  logic [HIST_W-1:0]  hist_q, hist_d, shifted;
  logic [SHIFT_W-1:0] shamt;

  always_comb begin
    // newest bit at the LSB, so the earliest bit of a window is its MSB
    hist_d  = {hist_q[HIST_W-3:0], pair_i};
    shamt   = SHIFT_W'(base_i) + SHIFT_W'(slip_i);
    shifted = hist_d >> shamt;
    sym_o   = shifted[SYM_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end
endmodule

// File: rtl/gb_align_ctrl.sv
module gb_align_ctrl
  import lvds_gear_pkg::*;
#(
  parameter int unsigned    SYM_W        = 7,
  parameter int unsigned    SLIP_W       = 3,
  parameter int unsigned    LOCK_MATCHES = 4,
  parameter int unsigned    LOSS_MISSES  = 2,
  parameter int unsigned    SETTLE_SYMS  = 2,
  parameter logic [SYM_W-1:0] CLK_PATTERN = 7'b1100011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic [SYM_W-1:0]  clk_sym_i,
  output logic [SLIP_W-1:0] slip_o,
  output logic              locked_o,
  output logic              lock_nxt_o
);
  localparam int unsigned RUN_W  = $clog2(LOCK_MATCHES + 2);
  localparam int unsigned MISS_W = $clog2(LOSS_MISSES + 2);
  localparam int unsigned SET_W  = $clog2(SETTLE_SYMS + 2);

  align_st_e         st_q, st_d;
  logic [RUN_W-1:0]  run_q, run_d;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic [SET_W-1:0]  settle_q, settle_d;
  logic [SLIP_W-1:0] slip_q, slip_d, slip_inc;
  logic              hit;

  always_comb begin
    st_d     = st_q;
    run_d    = run_q;
    miss_d   = miss_q;
    settle_d = settle_q;
    slip_d   = slip_q;
    hit      = (clk_sym_i == CLK_PATTERN);
    slip_inc = (slip_q == SLIP_W'(SYM_W - 1)) ? '0 : slip_q + 1'b1;
    if (stb_i) begin
      if (settle_q != '0) begin
        settle_d = settle_q - 1'b1;
      end else if (st_q == ST_HUNT) begin
        if (hit) begin
          if (run_q == RUN_W'(LOCK_MATCHES - 1)) begin
            st_d  = ST_LOCK;
            run_d = '0;
          end else begin
            run_d = run_q + 1'b1;
          end
        end else begin
          run_d    = '0;
          slip_d   = slip_inc;
          settle_d = SET_W'(SETTLE_SYMS);
        end
      end else begin
        if (hit) begin
          miss_d = '0;
        end else if (miss_q == MISS_W'(LOSS_MISSES - 1)) begin
          st_d     = ST_HUNT;
          miss_d   = '0;
          run_d    = '0;
          slip_d   = slip_inc;
          settle_d = SET_W'(SETTLE_SYMS);
        end else begin
          miss_d = miss_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_HUNT;
      run_q    <= '0;
      miss_q   <= '0;
      settle_q <= '0;
      slip_q   <= '0;
    end else if (stb_i) begin
      st_q     <= st_d;
      run_q    <= run_d;
      miss_q   <= miss_d;
      settle_q <= settle_d;
      slip_q   <= slip_d;
    end
  end

  assign slip_o     = slip_q;
  assign locked_o   = (st_q == ST_LOCK);
  assign lock_nxt_o = (st_d == ST_LOCK);
endmodule

// File: rtl/lvds71_rx_gearbox.sv
module lvds71_rx_gearbox #(
  parameter int unsigned      N_LANES      = 4,
  parameter int unsigned      SYM_W        = 7,
  parameter int unsigned      LOCK_MATCHES = 4,
  parameter int unsigned      LOSS_MISSES  = 2,
  parameter int unsigned      SETTLE_SYMS  = 2,
  parameter logic [SYM_W-1:0] CLK_PATTERN  = 7'b1100011
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2*N_LANES-1:0]       data_pair_i,
  input  logic [1:0]                 fwd_clk_pair_i,
  output logic [N_LANES*SYM_W-1:0]   word_o,
  output logic                       word_vld_o,
  output logic                       locked_o
);
  localparam int unsigned WORD_W  = N_LANES * SYM_W;
  localparam int unsigned HIST_W  = 2 * SYM_W;
  localparam int unsigned FILL_W  = $clog2(SYM_W + 2);
  localparam int unsigned SLIP_W  = $clog2(SYM_W);
  localparam int unsigned SHIFT_W = $clog2(HIST_W);

  logic              stb;
  logic [FILL_W-1:0] base;
  logic [SLIP_W-1:0] slip;
  logic              lock_nxt;
  logic [SYM_W-1:0]  syms [N_LANES+1];
  logic [WORD_W-1:0] word_nxt, word_d, word_q;
  logic              vld_d, vld_q;

  gb_bit_accum #(.SYM_W(SYM_W), .FILL_W(FILL_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .stb_o(stb), .base_o(base)
  );

  for (genvar g = 0; g <= N_LANES; g++) begin : g_lane
    logic [1:0] pair;
    if (g == N_LANES) begin : g_fwd
      assign pair = fwd_clk_pair_i;
    end else begin : g_dat
      assign pair = data_pair_i[2*g+1 -: 2];
      assign word_nxt[g*SYM_W +: SYM_W] = syms[g];
    end
    gb_lane_window #(
      .SYM_W(SYM_W), .HIST_W(HIST_W), .FILL_W(FILL_W),
      .SLIP_W(SLIP_W), .SHIFT_W(SHIFT_W)
    ) u_win (
      .clk(clk), .rst_n(rst_n), .pair_i(pair), .base_i(base),
      .slip_i(slip), .sym_o(syms[g])
    );
  end

  gb_align_ctrl #(
    .SYM_W(SYM_W), .SLIP_W(SLIP_W), .LOCK_MATCHES(LOCK_MATCHES),
    .LOSS_MISSES(LOSS_MISSES), .SETTLE_SYMS(SETTLE_SYMS),
    .CLK_PATTERN(CLK_PATTERN)
  ) u_align (
    .clk(clk), .rst_n(rst_n), .stb_i(stb), .clk_sym_i(syms[N_LANES]),
    .slip_o(slip), .locked_o(locked_o), .lock_nxt_o(lock_nxt)
  );

  always_comb begin
    vld_d  = stb & lock_nxt;
    word_d = vld_d ? word_nxt : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = vld_q;
endmodule

// File: rtl/lvds71_rx_gearbox_chk.sv
module lvds71_rx_gearbox_chk (
  input logic clk,
  input logic rst_n,
  input logic word_vld_o,
  input logic locked_o
);
  logic [2:0] gap_q, prev_gap_q;
  logic       have_q, have2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q      <= '0;
      prev_gap_q <= '0;
      have_q     <= 1'b0;
      have2_q    <= 1'b0;
    end else begin
      if (word_vld_o) gap_q <= 3'd1;
      else if (gap_q != 3'd7) gap_q <= gap_q + 3'd1;
      if (!locked_o) begin
        have_q  <= 1'b0;
        have2_q <= 1'b0;
      end else if (word_vld_o) begin
        have_q     <= 1'b1;
        have2_q    <= have_q;
        prev_gap_q <= gap_q;
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!locked_o && !word_vld_o));

  assert_gap_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_o && locked_o && have_q) |-> (gap_q == 3'd3 || gap_q == 3'd4));

  assert_gap_alternate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_o && locked_o && have2_q) |-> (gap_q != prev_gap_q));

  assert_lock_on_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> word_vld_o);

  assert_drop_no_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_o) |-> !word_vld_o);

  assert_valid_needs_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |-> locked_o);
endmodule

bind lvds71_rx_gearbox lvds71_rx_gearbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .word_vld_o(word_vld_o), .locked_o(locked_o)
);

// File: tb/tb_lvds71_rx_gearbox.sv
module tb_lvds71_rx_gearbox;
  localparam int CLK_PERIOD = 10;
  localparam int NPIX = 1024;
  localparam logic [6:0] PAT = 7'b1100011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  data_pair_i = '0;
  logic [1:0]  fwd_clk_pair_i = '0;
  logic [27:0] word_o;
  logic        word_vld_o, locked_o;

  lvds71_rx_gearbox dut (
    .clk(clk), .rst_n(rst_n), .data_pair_i(data_pair_i),
    .fwd_clk_pair_i(fwd_clk_pair_i), .word_o(word_o),
    .word_vld_o(word_vld_o), .locked_o(locked_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [27:0] px [NPIX];
  bit          corrupt [NPIX];
  int          off = 0;
  int          cyc_drv = 0;
  int          cyc_mon = 0;
  int          n_chk = 0, n_bad = 0;
  bit          chk_en = 0;
  int          exp_idx = -1;
  int          last_v = 0, prev_gap = 0;
  bit          have_last = 0;
  bit          done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // serial bit of a lane at stream position n (lane 4 = forwarded clock)
  function automatic logic stream_bit(int lane, int n);
    int pix, pos;
    if (n < 0) return 1'b0;
    pix = n / 7;
    pos = n % 7;
    if (lane == 4) return PAT[6-pos] ^ corrupt[pix];
    return px[pix][7*lane + 6 - pos];
  endfunction

  // driver: two bits per cycle, earlier bit in the upper position
  always @(negedge clk) begin
    if (!rst_n) cyc_drv = 0;
    else begin
      for (int k = 0; k < 4; k++) begin
        data_pair_i[2*k+1] = stream_bit(k, 2*cyc_drv - off);
        data_pair_i[2*k]   = stream_bit(k, 2*cyc_drv + 1 - off);
      end
      fwd_clk_pair_i[1] = stream_bit(4, 2*cyc_drv - off);
      fwd_clk_pair_i[0] = stream_bit(4, 2*cyc_drv + 1 - off);
      cyc_drv++;
    end
  end

  // monitor
  always @(negedge clk) begin
    cyc_mon++;
    if (!rst_n) begin
      exp_idx = -1; have_last = 0; prev_gap = 0;
    end else begin
      if (!locked_o) begin
        exp_idx = -1; have_last = 0; prev_gap = 0;
        check(!word_vld_o, "R7 valid while unlocked", word_vld_o, 0);
      end else if (word_vld_o) begin
        if (have_last) begin
          int gap;
          gap = cyc_mon - last_v;
          check(gap == 3 || gap == 4, "R3 word spacing", gap, 3);
          if (prev_gap != 0) check(gap != prev_gap, "R3 spacing alternation", gap, 7 - prev_gap);
          prev_gap = gap;
        end
        have_last = 1;
        last_v = cyc_mon;
        if (chk_en) begin
          if (exp_idx < 0) begin
            int found;
            found = -1;
            for (int i = 0; i < NPIX; i++)
              if (found < 0 && px[i] == word_o) found = i;
            check(found >= 0, "R2 R9 word not among sent pixels", word_o, 0);
            exp_idx = (found >= 0) ? found + 1 : -1;
          end else begin
            check(word_o == px[exp_idx], "R2 R9 pixel sequence", word_o, px[exp_idx]);
            exp_idx++;
          end
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input int phase);
    wait_cyc(1);
    rst_n = 1'b0;
    chk_en = 0;
    off = phase;
    for (int i = 0; i < NPIX; i++) corrupt[i] = 0;
    wait_cyc(3);
    check(!locked_o && !word_vld_o && word_o == '0, "R1 reset state",
          {word_o, word_vld_o, locked_o}, 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_lock(input bit want, input int limit, output bit got);
    got = 0;
    for (int i = 0; i < limit && !got; i++) begin
      wait_cyc(1);
      if (locked_o == want) got = 1;
    end
  endtask

  initial begin
    bit got, stayed;
    int cur;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NPIX; i++) px[i] = 28'($urandom());
    for (int k = 0; k < 4; k++) begin
      px[30+k] = 28'h1 << (7*k + 6);
      px[34+k] = 28'h1 << (7*k);
    end
    px[38] = 28'h0;
    px[39] = 28'hFFFFFFF;

    for (int p = 0; p < 7; p++) begin
      do_reset(p);
      wait_cyc(12);
      check(!locked_o, "R5 no lock before four matches", locked_o, 0);
      wait_cyc(138);
      check(locked_o, "R4 R8 lock from offset", p, 1);
      exp_idx = -1;
      chk_en = 1;
      wait_cyc(120);
    end

    // single corrupted clock symbol: lock must hold
    cur = (2*cyc_drv - off) / 7;
    corrupt[cur+3] = 1;
    stayed = 1;
    for (int i = 0; i < 40; i++) begin
      wait_cyc(1);
      if (!locked_o) stayed = 0;
    end
    check(stayed, "R6 single miss keeps lock", stayed, 1);

    // two consecutive corrupted symbols: lock must drop, then return
    cur = (2*cyc_drv - off) / 7;
    corrupt[cur+3] = 1;
    corrupt[cur+4] = 1;
    wait_lock(1'b0, 40, got);
    check(got, "R6 double miss drops lock", locked_o, 0);
    wait_lock(1'b1, 200, got);
    check(got, "R8 relock after loss", locked_o, 1);
    wait_cyc(100);

    // offset jump mid-stream
    chk_en = 0;
    off = off + 3;
    wait_lock(1'b0, 40, got);
    check(got, "R6 offset jump drops lock", locked_o, 0);
    wait_lock(1'b1, 200, got);
    check(got, "R8 relock after offset jump", locked_o, 1);
    exp_idx = -1;
    chk_en = 1;
    wait_cyc(150);

    // asynchronous reset in mid-stream
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check(!locked_o && !word_vld_o && word_o == '0, "R1 async reset clears",
          {word_o, word_vld_o, locked_o}, 0);
    wait_cyc(2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule